// File: doc/BRIEF.md
# Tapped-Delay SCL Clock Divider

This block turns a 6-bit divider code into the bit timing of an I2C master. It decodes the code into an SCL period and an SDA hold delay, both counted in system clocks. It then runs a free-running period counter that marks the SCL edges and the moment at which the bit engine may change SDA. The period is not a plain divide-by-N. Two small tap tables, each addressed by a 3-bit field gathered from scattered code bits, feed a tapped-delay sum.

The bit engine raises the enable and acts on three strobes. At `scl_fall` it drives SCL low. At `sda_update` it presents the next data bit. At `scl_rise` it releases SCL. The decoded `period` and `hold` are brought out so that the timing can be checked at the ports.

A new code is applied only at a period boundary, so a change never stretches or cuts a bit in flight. Dropping the enable parks SCL high and clears the counter.

Top module: `scl_tap_divider`

## Requirements
- R1: The code splits into two 3-bit indices. The row index r is code[4:2]. The column index c is {code[5], code[1:0]}, with code[5] as its most significant bit.
- R2: The row r = 0..7 selects the base delay B = 4, 4, 6, 6, 14, 30, 62, 126 and the step S = 2^r. The column c = 0..7 selects the period tap P = 9, 10, 12, 15, 5, 6, 7, 8 and the hold tap H = 3, 3, 4, 4, 1, 1, 2, 2. The output `period` equals 2 × (B + (P − 1) × S + 2).
- R3: The output `hold` equals B + (H − 1) × S + 3.
- R4: The code 000000 gives period 28 and hold 9. The code 111111 gives 2048 and 257. The code 100000 gives 20 and 7.
- R5: While running, `scl_fall` pulses for one cycle at the start of each period. `scl_level` is low for the first period/2 cycles and high for the rest. `scl_rise` pulses for one cycle period/2 cycles after `scl_fall`. The next `scl_fall` follows `period` cycles after the previous one.
- R6: `sda_update` pulses exactly `hold` cycles after each `scl_fall`, while `scl_level` is still low. It never coincides with either SCL strobe.
- R7: A code change made while running does not alter the current period or the `period`/`hold` outputs. It takes effect from the next `scl_fall`.
- R8: When `en` is sampled low, the next cycle shows `scl_level` high and no strobes. When `en` is sampled high after being low, `scl_fall` is asserted in the following cycle.
- R9: While disabled, `period` and `hold` follow `div_code` with one cycle of delay. After reset they show the values for code 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the divider; low parks SCL high |
| div_code | input | 6 | Divider code |
| scl_fall | output | 1 | One-cycle pulse: drive SCL low |
| scl_rise | output | 1 | One-cycle pulse: release SCL |
| sda_update | output | 1 | One-cycle pulse: SDA may change |
| scl_level | output | 1 | Intended SCL level |
| period | output | PER_W | Decoded SCL period in clocks |
| hold | output | HOLD_W | Decoded SDA hold in clocks |

## Verification
The properties assume that `div_code` may change at any cycle, including mid-period. They also assume that `en` is a level held for many cycles, not a pulse inside a period. The stimulus changes the code both while disabled and in the middle of a running period. It toggles `en` only between measured periods. The strobe-separation property relies on every table entry keeping the hold below half the period, and the code sweep covers all 64 codes to show that this is so.

// File: rtl/scl_tap_divider.sv
module scl_tap_divider #(
  parameter int PER_W  = 12,
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [5:0]        div_code,
  output logic              scl_fall,
  output logic              scl_rise,
  output logic              sda_update,
  output logic              scl_level,
  output logic [PER_W-1:0]  period,
  output logic [HOLD_W-1:0] hold
);

  logic [5:0]       act_code;
  logic             run;
  logic [PER_W-1:0] cnt;
  logic [2:0]       row, col;
  logic [PER_W-1:0] base, ptap, htap, hold_full, half;
  logic             wrap;

  assign row = act_code[4:2];
  assign col = {act_code[5], act_code[1:0]};

  always_comb begin
    case (row)
      3'd0, 3'd1: base = PER_W'(4);
      3'd2, 3'd3: base = PER_W'(6);
      3'd4:       base = PER_W'(14);
      3'd5:       base = PER_W'(30);
      3'd6:       base = PER_W'(62);
      default:    base = PER_W'(126);
    endcase
    case (col)
      3'd0:    begin ptap = PER_W'(9);  htap = PER_W'(3); end
      3'd1:    begin ptap = PER_W'(10); htap = PER_W'(3); end
      3'd2:    begin ptap = PER_W'(12); htap = PER_W'(4); end
      3'd3:    begin ptap = PER_W'(15); htap = PER_W'(4); end
      3'd4:    begin ptap = PER_W'(5);  htap = PER_W'(1); end
      3'd5:    begin ptap = PER_W'(6);  htap = PER_W'(1); end
      3'd6:    begin ptap = PER_W'(7);  htap = PER_W'(2); end
      default: begin ptap = PER_W'(8);  htap = PER_W'(2); end
    endcase
  end

  assign period    = (base + ((ptap - PER_W'(1)) << row) + PER_W'(2)) << 1;
  assign hold_full = base + ((htap - PER_W'(1)) << row) + PER_W'(3);
  assign hold      = hold_full[HOLD_W-1:0];
  assign half      = period >> 1;
  assign wrap      = run && (cnt == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      cnt      <= '0;
      act_code <= '0;
    end else begin
      run <= en;
      if (!en || !run || wrap) cnt <= '0;
      else                     cnt <= cnt + PER_W'(1);
      if (!run || wrap) act_code <= div_code;
    end
  end

  assign scl_fall   = run && (cnt == '0);
  assign scl_rise   = run && (cnt == half);
  assign sda_update = run && (cnt == PER_W'(hold));
  assign scl_level  = !run || (cnt >= half);

  // R6
  strobe_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_fall, scl_rise, sda_update}));

  // R8
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl_level && !scl_fall && !scl_rise && !sda_update));

  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scl_fall) |-> ($stable(period) && $stable(hold)));

  // R5
  low_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && en) |=> !scl_level);

  // R5
  rise_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> $past(!scl_level));

  // R6
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_update |-> !scl_level);

endmodule

// File: tb/scl_tap_divider_bench.sv
module scl_tap_divider_bench;
  localparam int PER_W  = 12;
  localparam int HOLD_W = 10;
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {6'b000000, 12'd28,   10'd9},
    {6'b111111, 12'd2048, 10'd257},
    {6'b100000, 12'd20,   10'd7},
    {6'b000001, 12'd30,   10'd9},
    {6'b000100, 12'd44,   10'd11},
    {6'b001000, 12'd80,   10'd17},
    {6'b010011, 12'd480,  10'd65},
    {6'b100011, 12'd26,   10'd8},
    {6'b011110, 12'd3072, 10'd513},
    {6'b111000, 12'd640,  10'd65}
  };

  logic clk = 0, rst_n = 0, en = 0;
  logic [5:0] div_code = '0;
  logic scl_fall, scl_rise, sda_update, scl_level;
  logic [PER_W-1:0] period;
  logic [HOLD_W-1:0] hold;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scl_tap_divider #(.PER_W(PER_W), .HOLD_W(HOLD_W)) u_scl_tap_divider (
    .clk(clk), .rst_n(rst_n), .en(en), .div_code(div_code),
    .scl_fall(scl_fall), .scl_rise(scl_rise), .sda_update(sda_update),
    .scl_level(scl_level), .period(period), .hold(hold));

  task automatic step(); @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_per(input logic [5:0] c, input bit want_hold);
    int r, k, b, p, h;
    r = int'(c[4:2]);
    k = int'({c[5], c[1:0]});
    case (r)
      0, 1: b = 4;
      2, 3: b = 6;
      4: b = 14;
      5: b = 30;
      6: b = 62;
      default: b = 126;
    endcase
    case (k)
      0: begin p = 9;  h = 3; end
      1: begin p = 10; h = 3; end
      2: begin p = 12; h = 4; end
      3: begin p = 15; h = 4; end
      4: begin p = 5;  h = 1; end
      5: begin p = 6;  h = 1; end
      6: begin p = 7;  h = 2; end
      default: begin p = 8; h = 2; end
    endcase
    if (want_hold) return b + (h - 1) * (1 << r) + 3;
    return 2 * (b + (p - 1) * (1 << r) + 2);
  endfunction

  task automatic measure(input logic [5:0] c, input int ep, input int eh);
    int t, tsda, trise, tnext, lvl_at_sda;
    en = 0; div_code = c;
    step(); step();
    check("R4 period", int'(period), ep);
    check("R4 hold", int'(hold), eh);
    en = 1;
    step();
    check("R8 first fall after enable", int'(scl_fall), 1);
    t = 0; tsda = -1; trise = -1; tnext = -1; lvl_at_sda = -1;
    while (tnext < 0 && t < 5000) begin
      step(); t++;
      if (sda_update) begin tsda = t; lvl_at_sda = int'(scl_level); end
      if (scl_rise) trise = t;
      if (scl_fall) tnext = t;
    end
    check("R6 sda_update delay", tsda, eh);
    check("R6 scl low at sda_update", lvl_at_sda, 0);
    check("R5 rise at half period", trise, ep / 2);
    check("R5 full period", tnext, ep);
    en = 0;
    step();
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int t;
    repeat (3) step();
    check("R9 reset scl_level", int'(scl_level), 1);
    check("R9 reset strobes", int'({scl_fall, scl_rise, sda_update}), 0);
    check("R9 reset period", int'(period), 28);
    check("R9 reset hold", int'(hold), 9);
    rst_n = 1;
    step();

    for (int v = 0; v < NV; v++)
      measure(VEC[v][27:22], int'(VEC[v][21:10]), int'(VEC[v][9:0]));

    // R1 R2 R3: sweep all codes while disabled
    for (int c = 0; c < 64; c++) begin
      div_code = 6'(c);
      step(); step();
      check("R2 sweep period", int'(period), exp_per(6'(c), 0));
      check("R3 sweep hold", int'(hold), exp_per(6'(c), 1));
    end

    // R1: scattered bits pick different columns
    div_code = 6'b100000; step(); step();
    check("R1 code[5] in column", int'(period), 20);
    div_code = 6'b000010; step(); step();
    check("R1 code[1] in column", int'(period), 34);

    // R7: mid-period code change
    div_code = 6'b000000; step(); step();
    en = 1; step();
    check("R7 start fall", int'(scl_fall), 1);
    repeat (5) step();
    div_code = 6'b100000;
    step();
    check("R7 period kept", int'(period), 28);
    check("R7 hold kept", int'(hold), 9);
    t = 6;
    while (!scl_fall && t < 200) begin step(); t++; end
    check("R7 old period finished", t, 28);
    check("R7 new period applied", int'(period), 20);
    t = 0;
    do begin step(); t++; end while (!scl_fall && t < 200);
    check("R7 new period length", t, 20);

    // R8: disable parks SCL high
    en = 0;
    step();
    check("R8 parked level", int'(scl_level), 1);
    t = 0;
    for (int k = 0; k < 40; k++) begin
      if (scl_fall || scl_rise || sda_update || !scl_level) t++;
      step();
    end
    check("R8 quiet while disabled", t, 0);
    // R9: outputs follow code while disabled
    div_code = 6'b111111; step();
    check("R9 follow period", int'(period), 2048);
    check("R9 follow hold", int'(hold), 257);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule